// File: doc/BRIEF.md
# SD Host Command Register Controller

This block lets software drive an SD/MMC card model through a small bank of 32-bit registers. Software loads a command index and a control word, and the controller issues the command to the card when the argument register is written. The card's reply comes back over a request/acknowledge handshake carrying up to four 32-bit words. The controller stores the reply in four response registers in a reordered form and raises busy flags in a status register.

The busy flags are reported once. The status read that returns them also clears them, so a polling driver sees each completed command exactly once. A separate data register moves payload words to and from the card one word per access. Accesses outside the decoded range, and writes to the status register, produce a one-cycle error pulse. Setting the soft-reset bit in the control register on its own also forces the clock-gate bit on.

Top module: `sdc_cmd_regs`

## Requirements
- R1: The register index is the byte address shifted right by 4. Indices 0 (control), 1 (command), 2 (argument), 3, 4, 5 and 6 are plain 32-bit read/write storage. A read returns the last value written, apart from the control-register rule in R10.
- R2: After reset, control reads 0xC0000000, status reads 0xE0000000 with bit 28 following `card_present`, index 0x11 reads the fixed value 0x03000000, and the other stored registers read 0.
- R3: A write to index 2 while control bit 16 is 1 raises `cmd_req` in the next cycle. It drives `cmd_idx` = index-1 bits [7:0], `cmd_arg` = the value written and `cmd_crc` = 0, and holds `cmd_req` until the cycle in which `cmd_ack` is 1. With control bit 16 at 0, the write starts nothing.
- R4: Issuing a command clears the four response registers (indices 8 to 11) to zero before any reply arrives.
- R5: With control bit 19 = 1 (long reply), response index 8+k receives card word 3-k, where card word j is `rsp_data[32j+31:32j]`, with its four bytes reversed.
- R6: With control bit 19 = 0, only index 8 is written, with card word 0 byte-reversed, and indices 9 to 11 stay zero.
- R7: When the card acknowledges, status bits 0 (busy) and 3 (command busy) are set. Bit 2 (data busy) is also set if control bit 24 was 1 when the command was issued.
- R8: A read of status (index 12) returns the current value, and status bits 0, 2 and 3 then read 0 on the next read. Bits 31..29 and 28 are unaffected.
- R9: A write to status leaves its contents unchanged and pulses `bus_err` for one cycle.
- R10: If a control write differs from the old value only in bit 31, and old bit 31 was 0, the stored value has bit 30 forced to 1. Otherwise the written value is stored as is.
- R11: A read of index 7 pulses `dat_pop` in the same cycle and returns `dat_rd_word`. A write of index 7 pulses `dat_push` with `dat_wr_word` equal to the written value.
- R12: An access to an index above 0x11 reads 0, changes no register, and pulses `bus_err` for one cycle.
- R13: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | One-cycle error pulse |
| cmd_req | output | 1 | Command request to card |
| cmd_idx | output | 8 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 7 | Command CRC (always zero) |
| cmd_ack | input | 1 | Card reply strobe |
| rsp_data | input | 32*RSP_WORDS | Card reply words |
| dat_pop | output | 1 | Data word consumed from card |
| dat_rd_word | input | 32 | Data word from card |
| dat_push | output | 1 | Data word sent to card |
| dat_wr_word | output | 32 | Data word to card |
| card_present | input | 1 | Card detect |

## Verification
A wrong response ordering or a missed clear shows as wrong words at indices 8 to 11. These are read straight after the acknowledge, so the error is visible within a few cycles of the reply. A stuck or lost busy flag appears on the first or second status read after each command. The second read must come back with the busy bits clear, so a missing clear cannot hide. A request that drops early, or a command fired while disabled, shows on `cmd_req` in the cycle after the argument write.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int IX_CTRL    = 0;
  localparam int IX_CMD     = 1;
  localparam int IX_ARG     = 2;
  localparam int N_PLAIN    = 7;
  localparam int IX_DATA    = 7;
  localparam int IX_RESP    = 8;
  localparam int IX_STATUS  = 12;
  localparam int IX_VERSION = 17;

  localparam int B_ENABLE   = 16;
  localparam int B_LONG     = 19;
  localparam int B_XFER     = 24;
  localparam int B_SOFTRST  = 31;
  localparam int B_CLKGATE  = 30;

  localparam int S_BUSY     = 0;
  localparam int S_DBUSY    = 2;
  localparam int S_CBUSY    = 3;
  localparam int S_CARD     = 28;

  localparam logic [31:0] CTRL_INIT   = 32'hC000_0000;
  localparam logic [31:0] STATUS_INIT = 32'hE000_0000;
  localparam logic [31:0] VERSION_VAL = 32'h0300_0000;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = w[8*(3-b) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] ctrl_next(input logic [31:0] old_v,
                                            input logic [31:0] new_v);
    logic [31:0] r;
    r = new_v;
    if (((old_v ^ new_v) == (32'h1 << B_SOFTRST)) && !old_v[B_SOFTRST])
      r[B_CLKGATE] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] plain_init(input int ix);
    return (ix == IX_CTRL) ? CTRL_INIT : 32'h0;
  endfunction
endpackage

// File: rtl/sdc_addr_dec.sv
module sdc_addr_dec #(
  parameter int IDX_W = 8
) (
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [IDX_W-1:0] idx,
  input  logic             enable,
  input  logic             busy_cmd,
  output logic             plain_wr,
  output logic             fire,
  output logic             stat_rd,
  output logic             stat_wr,
  output logic             data_rd,
  output logic             data_wr,
  output logic             bad_acc
);
  import sdc_pkg::*;

  logic in_range;

  always_comb begin
    in_range = (idx <= IDX_W'(IX_VERSION));
    bad_acc  = (bus_wr | bus_rd) & ~in_range;
    plain_wr = bus_wr & (idx < IDX_W'(N_PLAIN));
    fire     = bus_wr & (idx == IDX_W'(IX_ARG)) & enable & ~busy_cmd;
    stat_rd  = bus_rd & (idx == IDX_W'(IX_STATUS));
    stat_wr  = bus_wr & (idx == IDX_W'(IX_STATUS));
    data_rd  = bus_rd & (idx == IDX_W'(IX_DATA));
    data_wr  = bus_wr & (idx == IDX_W'(IX_DATA));
  end
endmodule

// File: rtl/sdc_plain_bank.sv
module sdc_plain_bank #(
  parameter int IDX_W  = 8,
  parameter int NREG   = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [31:0]            wdata,
  output logic [NREG-1:0][31:0]  regs
);
  import sdc_pkg::*;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= plain_init(g);
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        if (g == IX_CTRL) regs[g] <= ctrl_next(regs[g], wdata);
        else              regs[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/sdc_cmd_seq.sv
module sdc_cmd_seq #(
  parameter int NW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [7:0]           idx_in,
  input  logic [31:0]          arg_in,
  input  logic                 long_in,
  input  logic                 xfer_in,
  input  logic                 ack,
  input  logic [NW*32-1:0]     rsp,
  output logic                 req,
  output logic [7:0]           idx_q,
  output logic [31:0]          arg_q,
  output logic [NW-1:0][31:0]  resp,
  output logic                 done,
  output logic                 done_xfer
);
  import sdc_pkg::*;

  logic long_q, xfer_q;

  assign done      = req & ack;
  assign done_xfer = done & xfer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req    <= 1'b0;
      idx_q  <= '0;
      arg_q  <= '0;
      long_q <= 1'b0;
      xfer_q <= 1'b0;
      resp   <= '0;
    end else if (fire) begin
      req    <= 1'b1;
      idx_q  <= idx_in;
      arg_q  <= arg_in;
      long_q <= long_in;
      xfer_q <= xfer_in;
      resp   <= '0;
    end else if (done) begin
      req <= 1'b0;
      if (long_q) begin
        for (int k = 0; k < NW; k++)
          resp[k] <= bswap32(rsp[32*(NW-1-k) +: 32]);
      end else begin
        resp[0] <= bswap32(rsp[31:0]);
      end
    end
  end
endmodule

// File: rtl/sdc_status_trk.sv
module sdc_status_trk (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        done,
  input  logic        done_xfer,
  input  logic        clr,
  input  logic        card_present,
  output logic [31:0] stat_q,
  output logic [31:0] stat_view
);
  import sdc_pkg::*;

  logic [31:0] busy_mask, set_bits, stat_d;

  always_comb begin
    busy_mask = (32'h1 << S_BUSY) | (32'h1 << S_DBUSY) | (32'h1 << S_CBUSY);
    set_bits  = '0;
    if (done) set_bits = (32'h1 << S_BUSY) | (32'h1 << S_CBUSY);
    if (done_xfer) set_bits[S_DBUSY] = 1'b1;
    stat_d = (clr ? (stat_q & ~busy_mask) : stat_q) | set_bits;
    stat_view = stat_q;
    stat_view[S_CARD] = card_present;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STATUS_INIT;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/sdc_cmd_regs.sv
module sdc_cmd_regs #(
  parameter int ADDR_W    = 12,
  parameter int RSP_WORDS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   bus_rvalid,
  output logic                   bus_err,
  output logic                   cmd_req,
  output logic [7:0]             cmd_idx,
  output logic [31:0]            cmd_arg,
  output logic [6:0]             cmd_crc,
  input  logic                   cmd_ack,
  input  logic [32*RSP_WORDS-1:0] rsp_data,
  output logic                   dat_pop,
  input  logic [31:0]            dat_rd_word,
  output logic                   dat_push,
  output logic [31:0]            dat_wr_word,
  input  logic                   card_present
);
  import sdc_pkg::*;

  localparam int IDX_W = ADDR_W - 4;
  localparam int PL_W  = $clog2(N_PLAIN);
  localparam int RS_W  = $clog2(RSP_WORDS);

  logic [IDX_W-1:0] idx;
  logic plain_wr, cmd_fire, stat_rd, stat_wr, data_rd, data_wr, bad_acc;
  logic cmd_done, cmd_done_xfer;
  logic [N_PLAIN-1:0][31:0] bank_q;
  logic [RSP_WORDS-1:0][31:0] resp_q;
  logic [31:0] status_q, status_view, ctrl_q, rd_mux;
  logic unused_lowaddr;

  assign idx            = bus_addr[ADDR_W-1:4];
  assign unused_lowaddr = ^bus_addr[3:0];
  assign ctrl_q         = bank_q[IX_CTRL];

  sdc_addr_dec #(.IDX_W(IDX_W)) dec_i (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .idx(idx),
    .enable(ctrl_q[B_ENABLE]), .busy_cmd(cmd_req),
    .plain_wr(plain_wr), .fire(cmd_fire), .stat_rd(stat_rd),
    .stat_wr(stat_wr), .data_rd(data_rd), .data_wr(data_wr),
    .bad_acc(bad_acc)
  );

  sdc_plain_bank #(.IDX_W(IDX_W), .NREG(N_PLAIN)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(plain_wr), .wr_idx(idx),
    .wdata(bus_wdata), .regs(bank_q)
  );

  sdc_cmd_seq #(.NW(RSP_WORDS)) seq_i (
    .clk(clk), .rst_n(rst_n), .fire(cmd_fire),
    .idx_in(bank_q[IX_CMD][7:0]), .arg_in(bus_wdata),
    .long_in(ctrl_q[B_LONG]), .xfer_in(ctrl_q[B_XFER]),
    .ack(cmd_ack), .rsp(rsp_data), .req(cmd_req),
    .idx_q(cmd_idx), .arg_q(cmd_arg), .resp(resp_q),
    .done(cmd_done), .done_xfer(cmd_done_xfer)
  );

  sdc_status_trk stat_i (
    .clk(clk), .rst_n(rst_n), .done(cmd_done), .done_xfer(cmd_done_xfer),
    .clr(stat_rd), .card_present(card_present),
    .stat_q(status_q), .stat_view(status_view)
  );

  assign cmd_crc     = '0;
  assign dat_pop     = data_rd;
  assign dat_push    = data_wr;
  assign dat_wr_word = bus_wdata;

  always_comb begin
    rd_mux = '0;
    if (idx < IDX_W'(N_PLAIN))
      rd_mux = bank_q[idx[PL_W-1:0]];
    else if (idx == IDX_W'(IX_DATA))
      rd_mux = dat_rd_word;
    else if (idx >= IDX_W'(IX_RESP) && idx < IDX_W'(IX_RESP + RSP_WORDS))
      rd_mux = resp_q[idx[RS_W-1:0]];
    else if (idx == IDX_W'(IX_STATUS))
      rd_mux = status_view;
    else if (idx == IDX_W'(IX_VERSION))
      rd_mux = VERSION_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_err    <= bad_acc | stat_wr;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sdc_cmd_regs_chk.sv
module sdc_cmd_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic              cmd_req,
  input logic              cmd_ack,
  input logic [6:0]        cmd_crc,
  input logic              cmd_done,
  input logic              stat_rd,
  input logic [31:0]       status_q
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> cmd_req);

  p_crc_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> (cmd_crc == 7'd0));

  p_done_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> (status_q[0] && status_q[3]));

  p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_req);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cmd_done) |=> (status_q[3:0] & 4'b1101) == 4'b0000);

  p_rvalid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_err_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past((bus_wr || bus_rd) &&
      ((bus_addr[ADDR_W-1:4] > (ADDR_W-4)'(17)) ||
       (bus_wr && bus_addr[ADDR_W-1:4] == (ADDR_W-4)'(12)))));
endmodule

bind sdc_cmd_regs sdc_cmd_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
  .cmd_req(cmd_req), .cmd_ack(cmd_ack), .cmd_crc(cmd_crc),
  .cmd_done(cmd_done), .stat_rd(stat_rd), .status_q(status_q)
);

// File: tb/sdc_cmd_regs_tb_top.sv
`timescale 1ns/1ps
module sdc_cmd_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, bus_err, cmd_req, dat_pop, dat_push;
  logic [7:0] cmd_idx;
  logic [31:0] cmd_arg, dat_wr_word;
  logic [6:0] cmd_crc;
  logic cmd_ack = 0;
  logic [127:0] rsp_data = '0;
  logic [31:0] dat_rd_word = 32'h5a00_0001;
  logic card_present = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] pushed_word;
  int push_cnt = 0;

  always #2.5 clk = ~clk;

  sdc_cmd_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .cmd_req(cmd_req),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
    .cmd_ack(cmd_ack), .rsp_data(rsp_data), .dat_pop(dat_pop),
    .dat_rd_word(dat_rd_word), .dat_push(dat_push),
    .dat_wr_word(dat_wr_word), .card_present(card_present)
  );

  always @(posedge clk) begin
    if (dat_pop) dat_rd_word <= dat_rd_word + 32'h0101_0101;
    if (dat_push) begin pushed_word <= dat_wr_word; push_cnt <= push_cnt + 1; end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] card_word(input int j, input logic [7:0] ci, input logic [31:0] a);
    return (a ^ (32'h1111_0000 * (j + 1))) + {24'h0, ci} + 32'h0102_0304 * j;
  endfunction

  logic last_err;
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; last_err = bus_err;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata; last_err = bus_err;
    check(bus_rvalid === 1'b1, "R13 rvalid", {31'h0, bus_rvalid}, 32'h1);
  endtask

  task automatic run_cmd(input logic [7:0] ci, input logic [31:0] a, input bit lng, input bit xf);
    logic [31:0] v, st, w [4];
    logic [31:0] ctrl;
    ctrl = 32'h0001_0000 | (lng ? 32'h0008_0000 : 0) | (xf ? 32'h0100_0000 : 0);
    wr(12'h000, ctrl);
    wr(12'h010, {24'hABCDEF, ci});
    wr(12'h020, a);
    check(cmd_req === 1'b1, "R3 req", {31'h0, cmd_req}, 32'h1);
    check(cmd_idx == ci && cmd_arg == a && cmd_crc == 0, "R3 idx/arg/crc", cmd_arg, a);
    for (int k = 0; k < 4; k++) begin
      rd(12'h080 + 12'(k * 16), v);
      check(v == 0, "R4 cleared", v, 0);
    end
    check(cmd_req === 1'b1, "R3 hold", {31'h0, cmd_req}, 32'h1);
    for (int j = 0; j < 4; j++) w[j] = card_word(j, ci, a);
    @(negedge clk); cmd_ack = 1; rsp_data = {w[3], w[2], w[1], w[0]};
    @(negedge clk); cmd_ack = 0; rsp_data = '0;
    check(cmd_req === 1'b0, "R3 drop", {31'h0, cmd_req}, 0);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] e;
      rd(12'h080 + 12'(k * 16), v);
      if (lng) e = rev(w[3 - k]); else e = (k == 0) ? rev(w[0]) : 32'h0;
      check(v == e, lng ? "R5 long resp" : "R6 short resp", v, e);
    end
    rd(12'h0C0, st);
    v = 32'hE000_0000 | {3'b0, card_present, 28'h0} | 32'h9 | (xf ? 32'h4 : 0);
    check(st == v, "R7 status set", st, v);
    rd(12'h0C0, st);
    v = 32'hE000_0000 | {3'b0, card_present, 28'h0};
    check(st == v, "R8 status cleared", st, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset values
    rd(12'h000, v); check(v == 32'hC000_0000, "R2 ctrl", v, 32'hC000_0000);
    rd(12'h0C0, v); check(v == 32'hE000_0000, "R2 status", v, 32'hE000_0000);
    rd(12'h110, v); check(v == 32'h0300_0000, "R2 version", v, 32'h0300_0000);
    for (int i = 1; i < 7; i++) begin
      rd(12'(i * 16), v); check(v == 0, "R2 plain zero", v, 0);
    end
    card_present = 1;
    rd(12'h0C0, v); check(v == 32'hF000_0000, "R8 card bit", v, 32'hF000_0000);
    // R1 plain storage sweep
    for (int i = 1; i < 7; i++) begin
      wr(12'(i * 16), 32'h1234_0000 + 32'(i * 32'h0011_0101));
    end
    for (int i = 1; i < 7; i++) begin
      e = 32'h1234_0000 + 32'(i * 32'h0011_0101);
      rd(12'(i * 16), v); check(v == e, "R1 storage", v, e);
    end
    // R10 soft reset
    wr(12'h000, 32'h0); wr(12'h000, 32'h8000_0000);
    rd(12'h000, v); check(v == 32'hC000_0000, "R10 forced", v, 32'hC000_0000);
    wr(12'h000, 32'h0); wr(12'h000, 32'h8000_0001);
    rd(12'h000, v); check(v == 32'h8000_0001, "R10 not forced", v, 32'h8000_0001);
    wr(12'h000, 32'h8000_0000);
    rd(12'h000, v); check(v == 32'h8000_0000, "R10 already set", v, 32'h8000_0000);
    // R3 disabled
    wr(12'h000, 32'h0); wr(12'h020, 32'hDEAD_BEEF);
    check(cmd_req === 1'b0, "R3 disabled", {31'h0, cmd_req}, 0);
    // command sweep
    for (int c = 0; c < 3; c++)
      for (int l = 0; l < 2; l++)
        for (int x = 0; x < 2; x++)
          run_cmd(8'(c * 17 + 2), 32'h3000_0007 * (c + 1) + 32'(l * 5 + x), l[0], x[0]);
    // R9 status write
    wr(12'h0C0, 32'h0000_000F);
    check(last_err === 1'b1, "R9 err", {31'h0, last_err}, 1);
    @(negedge clk); check(bus_err === 1'b0, "R9 one cycle", {31'h0, bus_err}, 0);
    rd(12'h0C0, v); check(v == 32'hF000_0000, "R9 unchanged", v, 32'hF000_0000);
    // R11 data port
    e = dat_rd_word;
    rd(12'h070, v); check(v == e, "R11 pop word", v, e);
    rd(12'h070, v); check(v == e + 32'h0101_0101, "R11 next word", v, e + 32'h0101_0101);
    wr(12'h070, 32'hCAFE_F00D);
    @(negedge clk);
    check(push_cnt == 1 && pushed_word == 32'hCAFE_F00D, "R11 push", pushed_word, 32'hCAFE_F00D);
    // R12 out of range
    wr(12'h120, 32'hFFFF_FFFF);
    check(last_err === 1'b1, "R12 wr err", {31'h0, last_err}, 1);
    rd(12'hFF0, v); check(v == 0 && last_err === 1'b1, "R12 rd zero", v, 0);
    rd(12'h0D0, v); check(v == 0 && last_err === 1'b0, "R12 gap no err", v, 0);
    for (int i = 1; i < 7; i++) begin
      e = 32'h1234_0000 + 32'(i * 32'h0011_0101);
      if (i == 1) e = {24'hABCDEF, 8'(2 * 17 + 2)};
      if (i == 2) e = 32'h3000_0007 * 3 + 6;
      rd(12'(i * 16), v); check(v == e, "R12 no side effect", v, e);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule